// File: doc/BRIEF.md
# Clock Update Cycle Controller

This block paces the once-per-second update of a real-time clock's time registers. A clock-enable pulse arrives at the 32.768 kHz rate and drives a one-second tick counter. Once a second the counter starts an update window. Before that, the block raises an update-in-progress flag a fixed guard time ahead of the window. Software that sees the flag low therefore knows that no update will begin for at least the guard time. The time, calendar and alarm registers are then stable and safe to read.

A three-bit oscillator-control code sets what runs. Code `010` runs the oscillator and the tick counter. Codes `11x` keep the oscillator running but hold the counter at its half-second restart point, so no update occurs. Every other code stops both. Entering `010` from any other code places the first update half a second later. A software inhibit input lets software load new time values. While it is high, no update can start and the flag is cleared, but the tick counter keeps its phase.

The outputs are the flag, a one-cycle strobe that tells the time counters to advance, the update-active window, and an oscillator-running indication. All outputs are registered.

Top module: `upd_cycle_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), every output goes to 0 on the next clock edge, and the tick counter returns to its half-second point.
- R2: With `osc_ctl` = 3'b010 and `set_inhibit` low, `osc_en` is 1 and update strobes repeat exactly every SEC_TICKS ticks.
- R3: After `osc_ctl` changes to 3'b010 from any other code, the first `upd_strobe` follows SEC_TICKS/2 ticks later.
- R4: `uip` rises on the tick that leaves exactly GUARD_TICKS ticks before the update. An update starts only if `uip` was already high in the cycle before the strobe, so an update never begins without a full guard period.
- R5: `upd_strobe` is high for a single cycle. `upd_active` rises in that same cycle and stays high for exactly UPD_TICKS ticks.
- R6: `uip` stays high without a break from its rise until the end of the window, and it falls in the same cycle as `upd_active`.
- R7: One cycle after `set_inhibit` is seen high, `uip`, `upd_active` and `upd_strobe` are 0, and they stay 0 while it is held. The tick counter keeps counting, so after release the next update falls on the same one-second grid as before.
- R8: With `osc_ctl[2:1]` = 2'b11, `osc_en` is 1 and no flag or update appears. The counter is held, so a later switch to 3'b010 gives the first update SEC_TICKS/2 ticks later.
- R9: Codes 3'b000, 3'b001, 3'b011, 3'b100 and 3'b101 give `osc_en` = 0 and keep `uip`, `upd_strobe` and `upd_active` at 0.
- R10: In cycles where `tick` is low, neither the counter nor the update window advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| osc_ctl | input | 3 | Oscillator-control code (3'b010 run, 3'b11x hold, others stop) |
| set_inhibit | input | 1 | Software inhibit: blocks updates and clears the flag |
| uip | output | 1 | Update-in-progress flag, raised a guard time ahead of each update |
| upd_strobe | output | 1 | One-cycle pulse at the start of each update window |
| upd_active | output | 1 | High during the update window |
| osc_en | output | 1 | Oscillator running (codes 010 and 11x) |

## Verification
Every output is a register. Its new value depends on the inputs seen at one rising edge and can be observed from that edge until the next one. A cycle-accurate model in the bench advances on the same edge, and all four outputs are compared with it at every falling edge. This covers random tick gaps, random code changes and random inhibit pulses. Directed runs drive a tick on every cycle and count falling edges from the stimulus. With those runs the first strobe is due at edge SEC_TICKS/2, the flag is high for GUARD_TICKS cycles before the strobe, and the window lasts UPD_TICKS cycles. Inhibit and mode changes are sampled one edge after they are applied.

// File: rtl/upc_pkg.sv
package upc_pkg;

  localparam int OSC_W = 3;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_RUN  = 2'd2
  } osc_mode_e;

  // 010 runs everything, 11x keeps the oscillator alive with the divider held,
  // anything else stops both.
  function automatic osc_mode_e decode_osc(input logic [OSC_W-1:0] code);
    if (code == 3'b010)
      return MODE_RUN;
    else if (code[2:1] == 2'b11)
      return MODE_HOLD;
    else
      return MODE_STOP;
  endfunction

endpackage

// File: rtl/upc_osc_decode.sv
module upc_osc_decode
  import upc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OSC_W-1:0] osc_ctl,
  output logic             run,
  output logic             osc_en
);

  osc_mode_e mode;

  always_comb mode = decode_osc(osc_ctl);

  assign run = (mode == MODE_RUN);

  always_ff @(posedge clk) begin
    if (rst) osc_en <= 1'b0;
    else     osc_en <= (mode != MODE_STOP);
  end

endmodule

// File: rtl/upc_divider.sv
module upc_divider #(
  parameter int SEC_TICKS   = 32768,
  parameter int GUARD_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic wrap,
  output logic enter_warn
);

  localparam int             CW       = $clog2(SEC_TICKS);
  localparam logic [CW-1:0]  LAST     = CW'(SEC_TICKS - 1);
  localparam logic [CW-1:0]  RESTART  = CW'(SEC_TICKS / 2);
  localparam logic [CW-1:0]  WARN_PRE = CW'(SEC_TICKS - GUARD_TICKS - 1);

  logic [CW-1:0] cnt;

  // Held at the half-second point whenever the chain is not running, so the
  // first update after enabling lands half a second later.
  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= RESTART;
    else if (tick)
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  assign wrap       = run & tick & (cnt == LAST);
  assign enter_warn = run & tick & (cnt == WARN_PRE);

endmodule

// File: rtl/upc_window.sv
module upc_window #(
  parameter int UPD_TICKS = 66
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic inhibit,
  input  logic wrap,
  input  logic enter_warn,
  output logic uip,
  output logic strobe,
  output logic active
);

  localparam int            UW       = $clog2(UPD_TICKS + 1);
  localparam logic [UW-1:0] UCNT_END = UW'(UPD_TICKS - 1);

  logic [UW-1:0] ucnt, ucnt_n;
  logic          start, end_win, act_n, uip_n;

  // An update launches only if the flag has been up for the whole guard time.
  assign start   = wrap & uip;
  assign end_win = !start & active & tick & (ucnt == UCNT_END);

  always_comb begin
    act_n  = active;
    ucnt_n = ucnt;
    if (start) begin
      act_n  = 1'b1;
      ucnt_n = '0;
    end else if (active && tick) begin
      if (end_win) begin
        act_n  = 1'b0;
        ucnt_n = '0;
      end else begin
        ucnt_n = ucnt + UW'(1);
      end
    end
    uip_n = enter_warn | (uip & !end_win);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || inhibit) begin
      uip    <= 1'b0;
      strobe <= 1'b0;
      active <= 1'b0;
      ucnt   <= '0;
    end else begin
      uip    <= uip_n;
      strobe <= start;
      active <= act_n;
      ucnt   <= ucnt_n;
    end
  end

  p_strobe_warned_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(uip))
    else $error("strobe without prior warning");

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe)
    else $error("strobe longer than one cycle");

  p_window_opens_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> strobe)
    else $error("window opened without strobe");

  p_uip_until_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(uip) |-> ($fell(active) || $past(inhibit) || !$past(run)))
    else $error("flag dropped before window end");

  p_inhibit_clears_r7: assert property (@(posedge clk) disable iff (rst)
    $past(inhibit) |-> (!uip && !active && !strobe))
    else $error("inhibit did not clear outputs");

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!uip && !active && !strobe))
    else $error("activity while divider stopped");

endmodule

// File: rtl/upd_cycle_ctrl.sv
module upd_cycle_ctrl #(
  parameter int SEC_TICKS   = 32768,
  parameter int GUARD_TICKS = 8,
  parameter int UPD_TICKS   = 66
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_inhibit,
  output logic       uip,
  output logic       upd_strobe,
  output logic       upd_active,
  output logic       osc_en
);

  logic run, wrap, enter_warn;

  upc_osc_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .osc_ctl (osc_ctl),
    .run     (run),
    .osc_en  (osc_en)
  );

  upc_divider #(
    .SEC_TICKS   (SEC_TICKS),
    .GUARD_TICKS (GUARD_TICKS)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run),
    .wrap       (wrap),
    .enter_warn (enter_warn)
  );

  upc_window #(
    .UPD_TICKS (UPD_TICKS)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (run),
    .inhibit    (set_inhibit),
    .wrap       (wrap),
    .enter_warn (enter_warn),
    .uip        (uip),
    .strobe     (upd_strobe),
    .active     (upd_active)
  );

endmodule

// File: tb/upd_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module upd_cycle_ctrl_tb;

  localparam int SEC   = 64;
  localparam int GUARD = 4;
  localparam int UPD   = 8;
  localparam int HALF  = SEC / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] osc = 3'b000;
  logic       inh = 1'b0;
  logic       uip, stb, act, osc_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  upd_cycle_ctrl #(.SEC_TICKS(SEC), .GUARD_TICKS(GUARD), .UPD_TICKS(UPD)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .osc_ctl(osc), .set_inhibit(inh),
    .uip(uip), .upd_strobe(stb), .upd_active(act), .osc_en(osc_en)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  // Reference model built from the requirements
  int m_cnt = HALF, m_left = 0;
  bit m_act = 0, m_uip = 0, m_stb = 0, m_osc = 0;

  always @(posedge clk) begin
    bit run_m, wrap_m, enter_m, start_m, end_m;
    cyc <= cyc + 1;
    run_m = (osc == 3'b010);
    if (rst) begin
      m_cnt <= HALF; m_act <= 0; m_left <= 0; m_uip <= 0; m_stb <= 0; m_osc <= 0;
    end else begin
      m_osc <= (osc == 3'b010) || (osc[2:1] == 2'b11);
      if (!run_m) begin
        m_cnt <= HALF; m_act <= 0; m_left <= 0; m_uip <= 0; m_stb <= 0;
      end else begin
        wrap_m  = tick && (m_cnt == SEC - 1);
        enter_m = tick && (m_cnt == SEC - GUARD - 1);
        if (tick) m_cnt <= wrap_m ? 0 : m_cnt + 1;
        if (inh) begin
          m_act <= 0; m_left <= 0; m_uip <= 0; m_stb <= 0;
        end else begin
          start_m = wrap_m && m_uip;
          end_m   = !start_m && m_act && tick && (m_left == 1);
          m_stb <= start_m;
          if (start_m) begin
            m_act <= 1; m_left <= UPD;
          end else if (m_act && tick) begin
            m_left <= m_left - 1;
            if (end_m) m_act <= 0;
          end
          m_uip <= enter_m || (m_uip && !end_m);
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(uip == m_uip,    "R4 uip vs model",    uip,    m_uip);
      chk(stb == m_stb,    "R5 strobe vs model", stb,    m_stb);
      chk(act == m_act,    "R5 active vs model", act,    m_act);
      chk(osc_en == m_osc, "R8 osc_en vs model", osc_en, m_osc);
    end
  end

  task automatic wait_strobe(output int n, output int at);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!stb && n < 4 * SEC);
    at = cyc;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int n, t0, t1, k, hits;
    bit bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!uip && !stb && !act && !osc_en, "R1 reset outputs", {uip, stb, act, osc_en}, 0);

    // R3/R4: first update and guard length
    osc = 3'b010;
    n = 0; hits = 0;
    do begin
      @(negedge clk);
      n++;
      if (uip && !stb) hits++;
    end while (!stb && n < 4 * SEC);
    t0 = cyc;
    chk(n == HALF, "R3 first update delay", n, HALF);
    chk(hits == GUARD, "R4 guard cycles", hits, GUARD);
    chk(osc_en == 1'b1, "R2 osc_en in run", osc_en, 1);

    // R5/R6: window length, flag held through it
    k = 0; bad = 0;
    while (act && k < 4 * UPD) begin
      if (!uip) bad = 1;
      k++;
      @(negedge clk);
      chk(!stb, "R5 strobe single cycle", stb, 0);
    end
    chk(k == UPD, "R5 window length", k, UPD);
    chk(!bad, "R6 flag high in window", bad, 0);
    chk(!uip, "R6 flag falls with window", uip, 0);

    // R2: period
    wait_strobe(n, t1);
    chk(t1 - t0 == SEC, "R2 update period", t1 - t0, SEC);

    // R7: inhibit during the window
    @(negedge clk);
    inh = 1'b1;
    @(negedge clk);
    chk(!uip && !act, "R7 inhibit clears", {uip, act}, 0);
    hits = 0;
    repeat (150) begin
      @(negedge clk);
      if (uip || stb || act) hits++;
    end
    chk(hits == 0, "R7 quiet while inhibited", hits, 0);
    inh = 1'b0;
    wait_strobe(n, t0);
    chk((t0 - t1) % SEC == 0, "R7 grid kept after release", (t0 - t1) % SEC, 0);

    // R8: hold code
    osc = 3'b110;
    @(negedge clk);
    chk(osc_en == 1'b1, "R8 osc_en in hold", osc_en, 1);
    hits = 0;
    repeat (2 * SEC) begin
      @(negedge clk);
      if (uip || stb || act) hits++;
    end
    chk(hits == 0, "R8 no updates in hold", hits, 0);
    osc = 3'b010;
    wait_strobe(n, t0);
    chk(n == HALF, "R8 restart after hold", n, HALF);
    osc = 3'b111;
    @(negedge clk);
    chk(osc_en && !uip && !act, "R8 code 111", {osc_en, uip, act}, 4);

    // R9: stop codes
    foreach (n_stop_codes[i]) begin
      osc = n_stop_codes[i];
      hits = 0;
      repeat (SEC + 4) begin
        @(negedge clk);
        if (uip || stb || act || osc_en) hits++;
      end
      chk(hits == 0, "R9 stop code quiet", hits, 0);
    end

    // R10: no ticks, no progress
    osc = 3'b010;
    tick = 1'b0;
    hits = 0;
    repeat (3 * SEC) begin
      @(negedge clk);
      if (uip || stb || act) hits++;
    end
    chk(hits == 0, "R10 frozen without ticks", hits, 0);
    tick = 1'b1;
    wait_strobe(n, t0);
    chk(n == HALF, "R10 resumes where held", n, HALF);

    // Random phase, checked against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick = ($urandom % 3) != 0;
      if ($urandom % 400 == 0) begin
        case ($urandom % 6)
          0:       osc = 3'($urandom);
          1:       osc = 3'b110;
          default: osc = 3'b010;
        endcase
      end
      if ($urandom % 300 == 0) inh = ~inh;
      if ($urandom % 2500 == 0) rst = 1'b1; else rst = 1'b0;
    end
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end

  logic [2:0] n_stop_codes [5] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101};

endmodule